// File: doc/BRIEF.md
# PWM Generator with Sample FIFO

This block is a pulse-width modulation peripheral with a single output pin and a small word-wide register port. A programmable prescaler divides the core clock into ticks. A cycle counter runs through a fixed number of ticks per PWM cycle, and the output stays high while the counter is below the current duty sample.

Duty samples are not written straight into the comparator. Software pushes them into a four-entry queue. The counter takes exactly one entry from the queue at the start of every PWM cycle. This lets a driver line up several duty values ahead of time without racing the waveform. A status register reports how full the queue is and holds a sticky flag for pushes that were lost.

A self-clearing soft reset returns every register and the queue to the reset state. The clock-select field and the three low-power mode bits are stored and read back only.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After the hardware reset, the control, status and period registers read 0 and `pwm_out` is low.
- R2: The control register at offset 0x00 stores and reads back these fields: enable in bit 0, the prescaler minus one in bits 15:4, the clock select in bits 17:16, and three mode bits in 22, 23 and 24. All other bits read 0. The period register at offset 0x10 reads back its low 16 bits.
- R3: Each write to offset 0x0C pushes its low 16 bits into the sample queue. Status bits 2:0 at offset 0x04 give the number of filled entries, from 0 to 4.
- R4: A push made while the queue holds 4 entries is dropped and sets status bit 4. That bit stays set until a status write with bit 4 equal to 1.
- R5: One PWM cycle lasts (period + 2) ticks, and one tick lasts (prescaler field + 1) clocks.
- R6: Within a cycle, `pwm_out` is high while the tick count is below the active sample and low for the rest of the cycle. A sample of 0 keeps the output low, and a sample of period + 2 or more keeps it high.
- R7: One entry leaves the queue at the start of each cycle. This happens on the first cycle after enable and at every cycle boundary. If the queue is empty at that point, the previous sample is used again.
- R8: While enable is 0, `pwm_out` is low from the clock edge that cleared the bit onward, and the counters are held at zero. Sample writes are still accepted into the queue.
- R9: Writing 1 to control bit 3 clears all registers, the queue and the overflow flag. Bit 3 then reads 1 for 4 clocks and reads 0 afterwards. Register writes made during that window are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
Any error in the queue pointers or the occupancy count shows up at the ports in two ways. The status count read at the first enabled clock can be wrong. The duty seen in a later cycle can be wrong, and this shows within one PWM cycle of the entry that was mishandled. Errors in the prescaler or the cycle counter shift the falling edge or the cycle boundary, so the per-clock comparison catches them during the first cycle. Errors in the soft-reset sequencer show up as a busy window that is too long or too short, or as register values that survive the reset, when the registers are read back on the clocks right after the request.

// File: rtl/pwm_fifo_pkg.sv
`timescale 1ns/1ps
package pwm_fifo_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] OFF_CTRL = 5'h00;
  localparam logic [REG_AW-1:0] OFF_STAT = 5'h04;
  localparam logic [REG_AW-1:0] OFF_SAMP = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_PER  = 5'h10;

  localparam int PRE_W    = 12;
  localparam int B_EN     = 0;
  localparam int B_SWR    = 3;
  localparam int B_PRE_LO = 4;
  localparam int B_SEL_LO = 16;
  localparam int B_DBG    = 22;
  localparam int B_WAIT   = 23;
  localparam int B_DOZE   = 24;
  localparam int B_OVF    = 4;

  typedef struct packed {
    logic             doze;
    logic             wait_en;
    logic             dbg;
    logic [1:0]       clk_sel;
    logic [PRE_W-1:0] prescale;
    logic             enable;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.enable   = w[B_EN];
    c.prescale = w[B_PRE_LO +: PRE_W];
    c.clk_sel  = w[B_SEL_LO +: 2];
    c.dbg      = w[B_DBG];
    c.wait_en  = w[B_WAIT];
    c.doze     = w[B_DOZE];
    return c;
  endfunction
endpackage

// File: rtl/pwm_ctrl_regs.sv
`timescale 1ns/1ps
module pwm_ctrl_regs
  import pwm_fifo_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SWR_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_per,
  input  logic [31:0]      wdata,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] period,
  output logic             swr_busy
);
  localparam int SWR_W = (SWR_CYCLES > 1) ? $clog2(SWR_CYCLES) : 1;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic             busy_q, busy_d;
  logic [SWR_W-1:0] swr_q, swr_d;
  logic             upd;
  logic             unused_w;

  assign unused_w = ^wdata;

  always_comb begin
    ctrl_d = ctrl_q;
    per_d  = per_q;
    busy_d = busy_q;
    swr_d  = swr_q;
    if (busy_q) begin
      ctrl_d = '0;
      per_d  = '0;
      if (swr_q == '0) busy_d = 1'b0;
      else             swr_d  = swr_q - 1'b1;
    end else if (wr_ctrl && wdata[B_SWR]) begin
      ctrl_d = '0;
      per_d  = '0;
      busy_d = 1'b1;
      swr_d  = SWR_W'(SWR_CYCLES - 1);
    end else begin
      if (wr_ctrl) ctrl_d = ctrl_unpack(wdata);
      if (wr_per)  per_d  = wdata[CNT_W-1:0];
    end
  end

  assign upd = busy_q | wr_ctrl | wr_per;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
      busy_q <= 1'b0;
      swr_q  <= '0;
    end else if (upd) begin
      ctrl_q <= ctrl_d;
      per_q  <= per_d;
      busy_q <= busy_d;
      swr_q  <= swr_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign period   = per_q;
  assign swr_busy = busy_q;
endmodule

// File: rtl/pwm_sample_fifo.sv
`timescale 1ns/1ps
module pwm_sample_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  input  logic          ovf_clr,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             full, push_ok, pop_ok, push_drop;

  assign full      = (cnt_q == CW'(DEPTH));
  assign push_ok   = push & ~flush & ~full;
  assign push_drop = push & ~flush & full;
  assign pop_ok    = pop & ~flush & (cnt_q != '0);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (push_ok) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
      if (push_drop)    ovf_d = 1'b1;
      else if (ovf_clr) ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_ok && wp_q == PTR_W'(i)) mem[i] <= push_data;
    end
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);
  assign ovf   = ovf_q;
endmodule

// File: rtl/pwm_core.sv
`timescale 1ns/1ps
module pwm_core #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] prescale,
  input  logic [CNT_W-1:0] period,
  input  logic             flush,
  input  logic             fifo_empty,
  input  logic [CNT_W-1:0] fifo_head,
  output logic             pop,
  output logic             run,
  output logic [CNT_W:0]   cyc_cnt,
  output logic [CNT_W-1:0] active,
  output logic             pwm_out
);
  logic             run_q, run_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W:0]   cyc_q, cyc_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic [CNT_W:0]   last_val;
  logic             tick, wrap, start;

  assign last_val = {1'b0, period} + 1'b1;
  assign tick     = run_q & (pre_q == prescale);
  assign wrap     = tick & (cyc_q >= last_val);
  assign start    = enable & ~flush & (~run_q | wrap);
  assign pop      = start & ~fifo_empty;

  always_comb begin
    run_d = run_q;
    pre_d = pre_q;
    cyc_d = cyc_q;
    act_d = act_q;
    if (!enable || flush) begin
      run_d = 1'b0;
      pre_d = '0;
      cyc_d = '0;
      if (flush) act_d = '0;
    end else begin
      run_d = 1'b1;
      if (start) begin
        pre_d = '0;
        cyc_d = '0;
        if (pop) act_d = fifo_head;
      end else if (tick) begin
        pre_d = '0;
        cyc_d = cyc_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pre_q <= '0;
      cyc_q <= '0;
      act_q <= '0;
    end else begin
      run_q <= run_d;
      pre_q <= pre_d;
      cyc_q <= cyc_d;
      act_q <= act_d;
    end
  end

  assign run     = run_q;
  assign cyc_cnt = cyc_q;
  assign active  = act_q;
  assign pwm_out = enable & run_q & (cyc_q < {1'b0, act_q});
endmodule

// File: rtl/pwm_fifo_gen.sv
`timescale 1ns/1ps
module pwm_fifo_gen
  import pwm_fifo_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int SWR_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);
  localparam int FIFO_CW = $clog2(FIFO_DEPTH + 1);

  ctrl_t              ctrl;
  logic [CNT_W-1:0]   period_q;
  logic               swr_busy;
  logic               wr_ctrl, wr_per, wr_samp, wr_stat;
  logic [CNT_W-1:0]   fifo_head;
  logic [FIFO_CW-1:0] fifo_cnt;
  logic               fifo_empty, fifo_ovf, fifo_pop;
  logic               core_run;
  logic [CNT_W:0]     core_cyc;
  logic [CNT_W-1:0]   core_active;
  logic               ctrl_en;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign wr_ctrl = bus_wr & (bus_addr == OFF_CTRL);
  assign wr_per  = bus_wr & (bus_addr == OFF_PER);
  assign wr_samp = bus_wr & (bus_addr == OFF_SAMP) & ~swr_busy;
  assign wr_stat = bus_wr & (bus_addr == OFF_STAT) & ~swr_busy;
  assign ctrl_en = ctrl.enable;

  pwm_ctrl_regs #(.CNT_W(CNT_W), .SWR_CYCLES(SWR_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_per(wr_per),
    .wdata(bus_wdata), .ctrl(ctrl), .period(period_q), .swr_busy(swr_busy)
  );

  pwm_sample_fifo #(.DEPTH(FIFO_DEPTH), .W(CNT_W), .CW(FIFO_CW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(swr_busy), .push(wr_samp),
    .push_data(bus_wdata[CNT_W-1:0]), .pop(fifo_pop),
    .ovf_clr(wr_stat & bus_wdata[B_OVF]), .head(fifo_head),
    .count(fifo_cnt), .empty(fifo_empty), .ovf(fifo_ovf)
  );

  pwm_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .enable(ctrl_en), .prescale(ctrl.prescale),
    .period(period_q), .flush(swr_busy), .fifo_empty(fifo_empty),
    .fifo_head(fifo_head), .pop(fifo_pop), .run(core_run),
    .cyc_cnt(core_cyc), .active(core_active), .pwm_out(pwm_out)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CTRL: begin
        bus_rdata[B_EN]              = ctrl.enable;
        bus_rdata[B_SWR]             = swr_busy;
        bus_rdata[B_PRE_LO +: PRE_W] = ctrl.prescale;
        bus_rdata[B_SEL_LO +: 2]     = ctrl.clk_sel;
        bus_rdata[B_DBG]             = ctrl.dbg;
        bus_rdata[B_WAIT]            = ctrl.wait_en;
        bus_rdata[B_DOZE]            = ctrl.doze;
      end
      OFF_STAT: begin
        bus_rdata[FIFO_CW-1:0] = fifo_cnt;
        bus_rdata[B_OVF]       = fifo_ovf;
      end
      OFF_PER:  bus_rdata[CNT_W-1:0] = period_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_fifo_gen_chk.sv
`timescale 1ns/1ps
module pwm_fifo_gen_chk
  import pwm_fifo_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int CW         = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_out,
  input logic              ctrl_en,
  input logic              swr_busy,
  input logic [CW-1:0]     fifo_cnt,
  input logic              fifo_ovf,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [CNT_W:0]    core_cyc,
  input logic [CNT_W-1:0]  period_q,
  input logic [CNT_W-1:0]  core_active
);
  logic stat_clear;
  assign stat_clear = bus_wr && bus_addr == OFF_STAT && bus_wdata[B_OVF];

  // R8
  a_r8_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !pwm_out);
  // R3
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(FIFO_DEPTH));
  // R4
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ovf && !swr_busy && !stat_clear) |=> fifo_ovf);
  // R9
  a_r9_busy_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    swr_busy |=> (fifo_cnt == '0 && !fifo_ovf));
  a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    swr_busy |-> !pwm_out);
  // R6
  a_r6_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
    (core_active == '0) |-> !pwm_out);
  // R7
  a_r7_pop_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt < $past(fifo_cnt)) |-> core_cyc == '0);
  // R5
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(period_q) && core_cyc <= {1'b0, period_q} + 1'b1)
      |=> core_cyc <= {1'b0, period_q} + 1'b1);
endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk #(
  .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH), .CW(FIFO_CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .ctrl_en(ctrl_en),
  .swr_busy(swr_busy), .fifo_cnt(fifo_cnt), .fifo_ovf(fifo_ovf),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .core_cyc(core_cyc), .period_q(period_q), .core_active(core_active)
);

// File: tb/pwm_fifo_gen_tb.sv
`timescale 1ns/1ps
module pwm_fifo_gen_tb;
  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_STAT = 5'h04;
  localparam logic [4:0] A_SAMP = 5'h0C;
  localparam logic [4:0] A_PER  = 5'h10;
  localparam logic [31:0] CTRL_MASK = 32'h01C3_FFF1;

  logic        clk, rst_n, bus_wr, pwm_out;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int n_chk, n_fail;
  bit done;

  pwm_fifo_gen u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic soft_reset();
    wr(A_CTRL, 32'h8);
    repeat (5) @(negedge clk);
  endtask

  function automatic bit exp_out(int k, int len, int div, int n, int s0, int s1, int s2, int s3);
    int c, pos, s;
    c = k / (len * div);
    pos = k % (len * div);
    if (c > n - 1) c = n - 1;
    s = (c == 0) ? s0 : (c == 1) ? s1 : (c == 2) ? s2 : s3;
    return (pos / div) < s;
  endfunction

  // Runs one waveform pass covering R5, R6, R7 and returns with block enabled
  task automatic run_wave(input int p, input int div, input int n,
                          input int s0, input int s1, input int s2, input int s3);
    int len, mism;
    logic [31:0] v;
    soft_reset();
    len = p + 2;
    wr(A_PER, p);
    wr(A_SAMP, s0);
    if (n > 1) wr(A_SAMP, s1);
    if (n > 2) wr(A_SAMP, s2);
    if (n > 3) wr(A_SAMP, s3);
    wr(A_CTRL, ((div - 1) << 4) | 1);
    for (int c = 0; c < n + 2; c++) begin
      mism = 0;
      for (int j = 0; j < len * div; j++) begin
        @(negedge clk);
        if (c == 0 && j == 0) begin
          rd(A_STAT, v);
          check("R7 count after first pop", v, n - 1);
        end
        if (pwm_out !== exp_out(c * len * div + j, len, div, n, s0, s1, s2, s3)) mism++;
      end
      check($sformatf("R5 R6 R7 cycle %0d mismatching clocks", c), mism, 0);
    end
    rd(A_STAT, v);
    check("R7 queue drained", v, 0);
  endtask

  initial begin
    logic [31:0] v, w;
    n_chk = 0; n_fail = 0; done = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(A_CTRL, v); check("R1 ctrl reset", v, 0);
    rd(A_STAT, v); check("R1 status reset", v, 0);
    rd(A_PER, v);  check("R1 period reset", v, 0);
    check("R1 output reset", pwm_out, 0);

    w = 32'h81D3_ABC2 | (32'h2 << 16) | (32'h7 << 22);
    w[3] = 1'b0; w[0] = 1'b0;
    wr(A_CTRL, w);
    rd(A_CTRL, v); check("R2 ctrl fields", v, w & CTRL_MASK);
    for (int i = 0; i < 4; i++) begin
      w = $urandom() & ~32'h8;
      wr(A_CTRL, w);
      rd(A_CTRL, v); check("R2 ctrl random", v, w & CTRL_MASK);
      w = $urandom();
      wr(A_PER, w);
      rd(A_PER, v); check("R2 period random", v, w & 32'hFFFF);
    end
    wr(A_CTRL, 0);
    soft_reset();

    wr(A_SAMP, 5); wr(A_SAMP, 6); wr(A_SAMP, 7);
    rd(A_STAT, v); check("R3 R8 count three while disabled", v, 3);
    wr(A_SAMP, 8);
    rd(A_STAT, v); check("R3 count full", v, 4);
    wr(A_SAMP, 9);
    rd(A_STAT, v); check("R4 overflow set", v, 32'h14);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R4 overflow sticky", v, 32'h14);
    wr(A_STAT, 32'h10);
    rd(A_STAT, v); check("R4 overflow cleared", v, 4);
    wr(A_SAMP, 1);
    wr(A_PER, 9);

    wr(A_CTRL, 32'h0040_0078);
    rd(A_CTRL, v); check("R9 busy 0", v, 8);
    wr(A_PER, 5);
    rd(A_CTRL, v); check("R9 busy 1", v, 8);
    @(negedge clk); rd(A_CTRL, v); check("R9 busy 2", v, 8);
    @(negedge clk); rd(A_CTRL, v); check("R9 busy 3", v, 8);
    @(negedge clk); rd(A_CTRL, v); check("R9 busy ends", v, 0);
    rd(A_STAT, v); check("R9 queue and flag cleared", v, 0);
    rd(A_PER, v);  check("R9 period cleared, write ignored", v, 0);

    run_wave(3, 2, 3, 0, 2, 7, 0);
    check("R6 full duty high", pwm_out, 1);
    wr(A_CTRL, 32'h0);
    check("R8 output low on disable", pwm_out, 0);
    @(negedge clk);
    check("R8 output stays low", pwm_out, 0);

    for (int r = 0; r < 5; r++) begin
      int p, div, n;
      p = $urandom % 6;
      div = ($urandom % 3) + 1;
      n = ($urandom % 4) + 1;
      run_wave(p, div, n, $urandom % (p + 4), $urandom % (p + 4),
               $urandom % (p + 4), $urandom % (p + 4));
      wr(A_CTRL, 32'h0);
      check("R8 low after disable", pwm_out, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule